// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Interpolator

This block converts an 8-bit grey level into a 10-bit drive code. It follows a programmable transfer curve of 26 control points. The points are not evenly spaced. They sit close together at both ends of the grey range and far apart in the middle. For each lookup the block picks the segment that contains the grey level and interpolates in a straight line between the two points that bound that segment.

Software loads the curve one byte at a time through a write port that carries a byte index. Each point takes two bytes, so a full curve takes 52 bytes. While the curve loads, the block checks that every point is strictly above the one before it. It raises a sticky error flag if one is not.

Lookups run through a two-stage pipeline. The first stage finds the segment. The second stage multiplies, shifts and adds. A valid bit travels alongside each lookup.

Top module: `gamma_pwl_interp`

## Requirements
- R1: The control points sit at grey levels 0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128, 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255. A lookup at the grey level of point k (k from 0 to 24) returns the stored value of point k exactly.
- R2: For x[i] <= g < x[i+1], the code is V[i] + floor((V[i+1]-V[i])*(g-x[i]) / (x[i+1]-x[i])) on a rising curve.
- R3: Grey level 255 falls in the last segment (254 to 255) and returns the value of point 25.
- R4: Point k is loaded by two byte writes. Index 2k carries bits 9:8 in data bits 1:0, and data bits 7:2 of that byte are ignored. Index 2k+1 carries bits 7:0.
- R5: A write with an index from 52 to 63 changes no point and no flag.
- R6: `curve_loaded_o` is 0 after reset. It goes to 1 in the cycle after a write to index 51 and to 0 in the cycle after a write to index 0.
- R7: `curve_error_o` goes to 1 in the cycle after a write to index 2k+1 (k >= 1) that leaves point k not strictly greater than point k-1. It stays set until a write to index 0, which clears it in the following cycle.
- R8: `out_valid_o` copies `in_valid_i` two clock cycles later, and the matching result is on `out_code_o` in the same cycle.
- R9: `out_code_o` keeps its last value during cycles in which `out_valid_o` is 0.
- R10: After reset, both flags, `out_valid_o` and `out_code_o` are 0, and every point reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Curve byte write strobe |
| wr_idx_i | input | IDX_W | Byte index of the write |
| wr_data_i | input | 8 | Byte to write |
| in_valid_i | input | 1 | Lookup request valid |
| grey_i | input | 8 | Grey level to look up |
| out_valid_o | output | 1 | Result valid, two cycles after the request |
| out_code_o | output | PT_W | Interpolated drive code |
| curve_loaded_o | output | 1 | Last byte of the curve has been written |
| curve_error_o | output | 1 | Loaded curve is not strictly rising |

## Verification
The bench builds the block with its default parameters, PT_W = 10 and IDX_W = 6. A 10-bit code lets a curve reach near 0x3FF. A 6-bit index can address bytes 52 to 63, beyond the curve, so the bench can show that such writes are ignored. Against a linear curve and a curved one, the bench sweeps all 256 grey levels back to back. This covers every segment width (1, 2, 4, 8, 16 and 32) with a full pipeline, and it includes the single-step segment at the top. A point equal to the one before it shows the error flag is sticky and clears when a new load begins.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  localparam int NUM_PTS = 26;
  localparam int GREY_W  = 8;
  localparam int SEG_W   = $clog2(NUM_PTS);
  localparam int OFF_W   = 5;

  function automatic logic [GREY_W-1:0] knot_x(input int i);
    case (i)
      0:  knot_x = 8'd0;   1:  knot_x = 8'd1;   2:  knot_x = 8'd3;
      3:  knot_x = 8'd5;   4:  knot_x = 8'd7;   5:  knot_x = 8'd11;
      6:  knot_x = 8'd15;  7:  knot_x = 8'd23;  8:  knot_x = 8'd31;
      9:  knot_x = 8'd47;  10: knot_x = 8'd63;  11: knot_x = 8'd95;
      12: knot_x = 8'd127; 13: knot_x = 8'd128; 14: knot_x = 8'd160;
      15: knot_x = 8'd192; 16: knot_x = 8'd208; 17: knot_x = 8'd224;
      18: knot_x = 8'd232; 19: knot_x = 8'd240; 20: knot_x = 8'd244;
      21: knot_x = 8'd248; 22: knot_x = 8'd250; 23: knot_x = 8'd252;
      24: knot_x = 8'd254; default: knot_x = 8'd255;
    endcase
  endfunction

  // log2 of segment width; widths are powers of two
  function automatic int seg_shift(input int i);
    int w;
    int s;
    w = int'(knot_x(i + 1)) - int'(knot_x(i));
    s = 0;
    for (int b = 0; b < OFF_W + 1; b++) begin
      if ((1 << s) < w) s = s + 1;
    end
    return s;
  endfunction
endpackage

// File: rtl/gamma_curve_regs.sv
module gamma_curve_regs
  import gamma_pwl_pkg::*;
#(
  parameter int PT_W    = 10,
  parameter int IDX_W   = 6,
  parameter int N_PTS   = NUM_PTS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [7:0]                   wr_data_i,
  output logic [N_PTS-1:0][PT_W-1:0]   pts_o,
  output logic                         loaded_o,
  output logic                         error_o
);
  localparam int NUM_BYTES = 2 * N_PTS;
  localparam int HI_W      = PT_W - 8;
  localparam int PI_W      = IDX_W - 1;

  logic [N_PTS-1:0][PT_W-1:0] pts_q;
  logic                       loaded_q, error_q;
  logic                       in_range, is_lo, start_wr, last_wr, mono_bad;
  logic [PI_W-1:0]            pt_idx;
  logic [PT_W-1:0]            new_val, prev_val;

  assign in_range = wr_en_i && (wr_idx_i < IDX_W'(NUM_BYTES));
  assign is_lo    = wr_idx_i[0];
  assign pt_idx   = in_range ? wr_idx_i[IDX_W-1:1] : '0;
  assign start_wr = in_range && (wr_idx_i == '0);
  assign last_wr  = in_range && (wr_idx_i == IDX_W'(NUM_BYTES - 1));
  assign new_val  = {pts_q[pt_idx][PT_W-1:8], wr_data_i};
  assign prev_val = (pt_idx == '0) ? '0 : pts_q[pt_idx - 1'b1];
  assign mono_bad = in_range && is_lo && (pt_idx != '0) && (new_val <= prev_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_PTS; k++) pts_q[k] <= '0;
    end else if (in_range) begin
      if (is_lo) pts_q[pt_idx][7:0]      <= wr_data_i;
      else       pts_q[pt_idx][PT_W-1:8] <= wr_data_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      if (start_wr)     loaded_q <= 1'b0;
      else if (last_wr) loaded_q <= 1'b1;
      if (start_wr)      error_q <= 1'b0;
      else if (mono_bad) error_q <= 1'b1;
    end
  end

  assign pts_o    = pts_q;
  assign loaded_o = loaded_q;
  assign error_o  = error_q;
endmodule

// File: rtl/gamma_seg_find.sv
module gamma_seg_find
  import gamma_pwl_pkg::*;
#(
  parameter int N_PTS = NUM_PTS
) (
  input  logic [GREY_W-1:0] grey_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int N_CMP = N_PTS - 2;

  logic [N_CMP-1:0]  ge;
  logic [GREY_W-1:0] base_x;

  // interior knots only: grey 255 stays in the last segment
  for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
    assign ge[gi] = grey_i >= knot_x(gi + 1);
  end

  always_comb begin
    seg_o  = SEG_W'($countones(ge));
    base_x = knot_x(int'(seg_o));
    off_o  = OFF_W'(grey_i - base_x);
  end
endmodule

// File: rtl/gamma_interp_math.sv
module gamma_interp_math
  import gamma_pwl_pkg::*;
#(
  parameter int PT_W  = 10,
  parameter int N_PTS = NUM_PTS
) (
  input  logic [N_PTS-1:0][PT_W-1:0] pts_i,
  input  logic [SEG_W-1:0]           seg_i,
  input  logic [OFF_W-1:0]           off_i,
  output logic [PT_W-1:0]            code_o
);
  localparam int D_W = PT_W + 1;
  localparam int P_W = D_W + OFF_W + 1;

  logic [SEG_W-1:0]        seg_nx;
  logic [PT_W-1:0]         v0, v1;
  logic signed [P_W-1:0]   delta, prod, scaled, total;
  int                      sh;

  assign seg_nx = seg_i + 1'b1;
  assign v0     = pts_i[seg_i];
  assign v1     = pts_i[seg_nx];

  always_comb begin
    delta  = $signed(P_W'({1'b0, v1})) - $signed(P_W'({1'b0, v0}));
    prod   = delta * $signed(P_W'({1'b0, off_i}));
    sh     = seg_shift(int'(seg_i));
    scaled = prod >>> sh;
    total  = $signed(P_W'({1'b0, v0})) + scaled;
    code_o = total[PT_W-1:0];
  end
endmodule

// File: rtl/gamma_pwl_interp.sv
module gamma_pwl_interp
  import gamma_pwl_pkg::*;
#(
  parameter int PT_W  = 10,
  parameter int IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic              in_valid_i,
  input  logic [GREY_W-1:0] grey_i,
  output logic              out_valid_o,
  output logic [PT_W-1:0]   out_code_o,
  output logic              curve_loaded_o,
  output logic              curve_error_o
);
  logic [NUM_PTS-1:0][PT_W-1:0] pts;
  logic [SEG_W-1:0]             seg_d, s1_seg;
  logic [OFF_W-1:0]             off_d, s1_off;
  logic                         s1_valid;
  logic [PT_W-1:0]              code_d, code_q;
  logic                         valid_q;

  gamma_curve_regs #(.PT_W(PT_W), .IDX_W(IDX_W), .N_PTS(NUM_PTS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .pts_o    (pts),
    .loaded_o (curve_loaded_o),
    .error_o  (curve_error_o)
  );

  gamma_seg_find #(.N_PTS(NUM_PTS)) u_find (
    .grey_i(grey_i),
    .seg_o (seg_d),
    .off_o (off_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_seg   <= '0;
      s1_off   <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_seg <= seg_d;
        s1_off <= off_d;
      end
    end
  end

  gamma_interp_math #(.PT_W(PT_W), .N_PTS(NUM_PTS)) u_math (
    .pts_i (pts),
    .seg_i (s1_seg),
    .off_i (s1_off),
    .code_o(code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= s1_valid;
      if (s1_valid) code_q <= code_d;
    end
  end

  assign out_valid_o = valid_q;
  assign out_code_o  = code_q;
endmodule

// File: rtl/gamma_pwl_checker.sv
module gamma_pwl_checker #(
  parameter int PT_W  = 10,
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [PT_W-1:0]  out_code_o,
  input logic             curve_loaded_o,
  input logic             curve_error_o
);
  logic v1_q, v2_q;
  logic idx0, idx_last, idx_over;

  assign idx0     = wr_en_i && (wr_idx_i == '0);
  assign idx_last = wr_en_i && (wr_idx_i == IDX_W'(51));
  assign idx_over = wr_en_i && (wr_idx_i > IDX_W'(51));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid_i;
      v2_q <= v1_q;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v2_q); // R8
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_code_o)); // R9
  AST_LOADED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_last |=> curve_loaded_o); // R6
  AST_LOADED_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx0 |=> !curve_loaded_o); // R6
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx0 |=> !curve_error_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (curve_error_o && !idx0) |=> curve_error_o); // R7
  AST_OVER_IDX_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_over |=> ($stable(curve_loaded_o) && $stable(curve_error_o))); // R5
endmodule

bind gamma_pwl_interp gamma_pwl_checker #(.PT_W(PT_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_idx_i      (wr_idx_i),
  .in_valid_i    (in_valid_i),
  .out_valid_o   (out_valid_o),
  .out_code_o    (out_code_o),
  .curve_loaded_o(curve_loaded_o),
  .curve_error_o (curve_error_o)
);

// File: tb/gamma_pwl_interp_tb.sv
module gamma_pwl_interp_tb;
  localparam int PT_W  = 10;
  localparam int IDX_W = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [IDX_W-1:0] wr_idx_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic             in_valid_i = 1'b0;
  logic [7:0]       grey_i = '0;
  logic             out_valid_o;
  logic [PT_W-1:0]  out_code_o;
  logic             curve_loaded_o;
  logic             curve_error_o;

  int checks = 0;
  int errors = 0;
  int kx[26] = '{0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128,
                 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255};
  int cur[26];

  always #10 clk_i = ~clk_i;

  gamma_pwl_interp #(.PT_W(PT_W), .IDX_W(IDX_W)) u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .in_valid_i, .grey_i,
    .out_valid_o, .out_code_o, .curve_loaded_o, .curve_error_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_code(input int g);
    int i = 0;
    for (int k = 1; k <= 24; k++) if (g >= kx[k]) i = k;
    return cur[i] + ((cur[i+1] - cur[i]) * (g - kx[i])) / (kx[i+1] - kx[i]);
  endfunction

  task automatic wr_byte(input int idx, input int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = IDX_W'(idx); wr_data_i = 8'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load_curve(input bit junk_hi);
    for (int k = 0; k < 26; k++) begin
      wr_byte(2*k, (junk_hi ? 8'hFC : 8'h00) | ((cur[k] >> 8) & 3));
      wr_byte(2*k+1, cur[k] & 8'hFF);
    end
  endtask

  task automatic sweep(input string tag);
    for (int g = 0; g < 258; g++) begin
      @(negedge clk_i);
      if (g >= 2) begin
        int e = ref_code(g-2);
        string r;
        r = (g-2 == 255) ? "R3" : "R2";
        for (int k = 0; k < 25; k++) if (kx[k] == g-2) r = "R1";
        chk(out_valid_o == 1'b1, "R8 valid in sweep", out_valid_o, 1);
        chk(int'(out_code_o) == e, {r, " ", tag}, out_code_o, e);
      end
      in_valid_i = (g < 256);
      grey_i = 8'(g);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(out_valid_o == 0, "R10 out_valid", out_valid_o, 0);
    chk(out_code_o == 0, "R10 out_code", out_code_o, 0);
    chk(curve_loaded_o == 0, "R10 R6 loaded", curve_loaded_o, 0);
    chk(curve_error_o == 0, "R10 error", curve_error_o, 0);
    for (int k = 0; k < 26; k++) cur[k] = 0;
    sweep("R10 zero curve");
  endtask

  task automatic t_linear;
    for (int k = 0; k < 26; k++) cur[k] = 4*kx[k] + 1;
    load_curve(1'b0);
    chk(curve_loaded_o == 1, "R6 loaded after last byte", curve_loaded_o, 1);
    chk(curve_error_o == 0, "R7 no error on rising curve", curve_error_o, 0);
    sweep("linear");
  endtask

  task automatic t_curved_junk_hi;
    for (int k = 0; k < 26; k++) cur[k] = k*k + 10*k + 1;
    load_curve(1'b1);   // R4: upper bits of high byte set
    chk(curve_error_o == 0, "R4 R7 junk high bits no error", curve_error_o, 0);
    sweep("R4 curved");
  endtask

  task automatic t_out_of_range;
    for (int i = 52; i < 64; i++) wr_byte(i, 8'h00);
    wr_byte(63, 8'hFF);
    chk(curve_loaded_o == 1, "R5 loaded unchanged", curve_loaded_o, 1);
    chk(curve_error_o == 0, "R5 error unchanged", curve_error_o, 0);
    sweep("R5 curve intact");
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    in_valid_i = 1'b1; grey_i = 8'd100;
    @(negedge clk_i);
    in_valid_i = 1'b0; grey_i = 8'd3;
    chk(out_valid_o == 0, "R8 not valid after 1", out_valid_o, 0);
    @(negedge clk_i);
    chk(out_valid_o == 1, "R8 valid after 2", out_valid_o, 1);
    chk(int'(out_code_o) == ref_code(100), "R8 code g=100", out_code_o, ref_code(100));
    @(negedge clk_i);
    chk(out_valid_o == 0, "R8 single pulse", out_valid_o, 0);
    chk(int'(out_code_o) == ref_code(100), "R9 code held", out_code_o, ref_code(100));
    grey_i = 8'd200;
    repeat (3) @(negedge clk_i);
    chk(int'(out_code_o) == ref_code(100), "R9 code held idle", out_code_o, ref_code(100));
  endtask

  task automatic t_monotonic_error;
    for (int k = 0; k < 26; k++) cur[k] = 40*k;
    cur[9] = cur[8];
    for (int k = 0; k < 26; k++) begin
      wr_byte(2*k, (cur[k] >> 8) & 3);
      if (k == 0) chk(curve_loaded_o == 0, "R6 loaded cleared by index 0", curve_loaded_o, 0);
      wr_byte(2*k+1, cur[k] & 8'hFF);
      if (k == 8) chk(curve_error_o == 0, "R7 no error before flat point", curve_error_o, 0);
      if (k == 9) chk(curve_error_o == 1, "R7 error on equal point", curve_error_o, 1);
    end
    chk(curve_error_o == 1, "R7 error sticky", curve_error_o, 1);
    chk(curve_loaded_o == 1, "R6 loaded with error", curve_loaded_o, 1);
    wr_byte(0, 0);
    chk(curve_error_o == 0, "R7 error cleared by new load", curve_error_o, 0);
    chk(curve_loaded_o == 0, "R6 loaded cleared", curve_loaded_o, 0);
    wr_byte(1, 50);
    wr_byte(2, 0);
    wr_byte(3, 20);
    chk(curve_error_o == 1, "R7 error on falling point", curve_error_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_linear();
    t_latency();
    t_curved_junk_hi();
    t_out_of_range();
    t_monotonic_error();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule